// File: doc/BRIEF.md
# Register-Driven SPI Pin Port

This block lets software drive the lines of an SPI bus one edge at a time through a small register window. One register word sets the level of all three active-low chip selects, the serial clock and the serial data output. Software moves a bit out by writing the pin word twice: once with the clock low and the data bit set, then once with the clock high and the same data bit. Bytes go out most significant bit first.

The only hardware help is on the receive side. Each rising clock edge that software produces shifts the synchronized serial input into a receive word. The new bit enters at bit 0, so after four bytes the first byte received sits in the top byte. After a shorter transfer the valid bytes sit in the low-order positions. A function-select register gates the whole port. While it is clear, pin writes have no effect and the pins rest in their idle state. Chip selects 1 and 2 only work once their pins are routed, so a per-select routing input forces a select high while it is low.

Top module: `spi_bb_port`

## Requirements
- R1: After reset the port is off. All chip selects are high, SCLK is high, MOSI is low, the receive word reads 0 and the pin register (byte offset 0x8) reads 0x00070100.
- R2: The function-select register is at offset 0x0, bit 0 enables the port, and reads of it return 0. While the port is off, writes to offset 0x8 are ignored and the pins stay idle (selects high, SCLK high).
- R3: A write to offset 0x8 while the port is on drives the pins from the following clock cycle. Bits 18, 17 and 16 set chip selects 2, 1 and 0 high, bit 8 sets SCLK and bit 0 sets MOSI. Reads of offset 0x8 return only these bits.
- R4: While routing input bit i is 0, chip select i is high, whatever the pin word holds. The routing input acts without a clock delay.
- R5: A pin write that takes bit 8 from 0 to 1 shifts the synchronized MISO level into the receive word at offset 0xC.
- R6: Each captured bit enters at bit 0 and older bits move up by one. After 32 captures the first bit is bit 31, and after fewer captures the valid bits are the low-order ones.
- R7: Reading the receive word does not change it. Capturing continues past 32 bits, and the oldest bits drop out of the top.
- R8: A pin write that leaves bit 8 at 1, or takes it from 1 to 0, captures nothing.
- R9: The control register at offset 0x4 reads back the last value written to it. Writes to offset 0xC are ignored.
- R10: Turning the port off returns the pin register to its idle value. After the port is turned back on, the pins stay idle until the next pin write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset; bits 3:2 select the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| cs_route_en | input | 3 | Per-select routing enable |
| miso | input | 1 | Serial data input, asynchronous |
| spi_cs_n | output | 3 | Active-low chip selects |
| spi_sclk | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data output |

## Verification
The bench builds the block with its default parameters: a two-stage input synchronizer and a 32-bit receive word. With these values a full four-byte fill is reachable, along with the overflow past 32 bits and a short two-byte transfer that lands in the low half. The MISO level is settled several cycles before each rising clock write, so the synchronizer delay never decides which bit is captured.

// File: rtl/spi_bb_pkg.sv
package spi_bb_pkg;

    localparam int WORD_W   = 32;
    localparam int NUM_CS   = 3;
    localparam int CS_LSB   = 16;
    localparam int SCLK_BIT = 8;
    localparam int MOSI_BIT = 0;

    typedef enum logic [1:0] {
        REG_FSEL = 2'd0,
        REG_CTRL = 2'd1,
        REG_PINS = 2'd2,
        REG_RXD  = 2'd3
    } reg_sel_e;

    typedef struct packed {
        logic [NUM_CS-1:0] cs_hi;
        logic              sclk;
        logic              mosi;
    } pin_word_t;

    localparam pin_word_t PIN_IDLE = '{cs_hi: {NUM_CS{1'b1}}, sclk: 1'b1, mosi: 1'b0};

    function automatic pin_word_t unpack_pins(input logic [WORD_W-1:0] w);
        pin_word_t p;
        p.cs_hi = w[CS_LSB +: NUM_CS];
        p.sclk  = w[SCLK_BIT];
        p.mosi  = w[MOSI_BIT];
        return p;
    endfunction

    function automatic logic [WORD_W-1:0] pack_pins(input pin_word_t p);
        logic [WORD_W-1:0] w;
        w = '0;
        w[CS_LSB +: NUM_CS] = p.cs_hi;
        w[SCLK_BIT]         = p.sclk;
        w[MOSI_BIT]         = p.mosi;
        return w;
    endfunction

endpackage

// File: rtl/spi_bb_regs.sv
module spi_bb_regs
    import spi_bb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int RX_W   = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [WORD_W-1:0] bus_wdata,
    input  logic [RX_W-1:0]   rx_word,
    output logic              fs_en,
    output pin_word_t         pins,
    output logic              sclk_rise,
    output logic [WORD_W-1:0] bus_rdata
);

    reg_sel_e          sel;
    logic              wr_hit;
    logic              pins_wr;
    logic [WORD_W-1:0] ctrl_q;

    assign sel     = reg_sel_e'(bus_addr[3:2]);
    assign wr_hit  = bus_sel && bus_wr;
    assign pins_wr = wr_hit && (sel == REG_PINS) && fs_en;

    // A clock edge exists only as a change of the stored clock bit.
    assign sclk_rise = pins_wr && bus_wdata[SCLK_BIT] && !pins.sclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            fs_en  <= 1'b0;
            ctrl_q <= '0;
            pins   <= PIN_IDLE;
        end else begin
            if (wr_hit && sel == REG_FSEL)
                fs_en <= bus_wdata[0];
            if (wr_hit && sel == REG_CTRL)
                ctrl_q <= bus_wdata;
            if (!fs_en)
                pins <= PIN_IDLE;
            else if (pins_wr)
                pins <= unpack_pins(bus_wdata);
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            REG_FSEL: bus_rdata = '0;
            REG_CTRL: bus_rdata = ctrl_q;
            REG_PINS: bus_rdata = pack_pins(pins);
            REG_RXD:  bus_rdata = WORD_W'(rx_word);
        endcase
    end

endmodule

// File: rtl/spi_bb_pins.sv
module spi_bb_pins
    import spi_bb_pkg::*;
(
    input  logic              fs_en,
    input  pin_word_t         pins,
    input  logic [NUM_CS-1:0] cs_route_en,
    output logic [NUM_CS-1:0] spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi
);

    for (genvar i = 0; i < NUM_CS; i++) begin : g_cs
        assign spi_cs_n[i] = !fs_en || pins.cs_hi[i] || !cs_route_en[i];
    end

    assign spi_sclk = fs_en ? pins.sclk : PIN_IDLE.sclk;
    assign spi_mosi = fs_en ? pins.mosi : PIN_IDLE.mosi;

endmodule

// File: rtl/spi_bb_capture.sv
module spi_bb_capture #(
    parameter int SYNC_STAGES = 2,
    parameter int RX_W        = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            miso,
    input  logic            sclk_rise,
    output logic [RX_W-1:0] rx_word
);

    logic miso_s;

    if (SYNC_STAGES == 0) begin : g_nosync
        assign miso_s = miso;
    end else begin : g_sync
        logic [SYNC_STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '0;
            else     chain <= {chain[SYNC_STAGES-2:0], miso};
        end
        assign miso_s = chain[SYNC_STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst)
            rx_word <= '0;
        else if (sclk_rise)
            rx_word <= {rx_word[RX_W-2:0], miso_s};
    end

endmodule

// File: rtl/spi_bb_port.sv
module spi_bb_port
    import spi_bb_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2,
    parameter int RX_W        = WORD_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [2:0]        cs_route_en,
    input  logic              miso,
    output logic [2:0]        spi_cs_n,
    output logic              spi_sclk,
    output logic              spi_mosi
);

    logic            fs_en;
    pin_word_t       pins;
    logic            sclk_rise;
    logic [RX_W-1:0] rx_word;

    spi_bb_regs #(.ADDR_W(ADDR_W), .RX_W(RX_W)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_sel   (bus_sel),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .rx_word   (rx_word),
        .fs_en     (fs_en),
        .pins      (pins),
        .sclk_rise (sclk_rise),
        .bus_rdata (bus_rdata)
    );

    spi_bb_pins u_pins (
        .fs_en       (fs_en),
        .pins        (pins),
        .cs_route_en (cs_route_en),
        .spi_cs_n    (spi_cs_n),
        .spi_sclk    (spi_sclk),
        .spi_mosi    (spi_mosi)
    );

    spi_bb_capture #(.SYNC_STAGES(SYNC_STAGES), .RX_W(RX_W)) u_cap (
        .clk       (clk),
        .rst       (rst),
        .miso      (miso),
        .sclk_rise (sclk_rise),
        .rx_word   (rx_word)
    );

endmodule

// File: rtl/spi_bb_port_chk.sv
module spi_bb_port_chk
    import spi_bb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int RX_W   = WORD_W
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              fs_en,
    input logic [2:0]        cs_route_en,
    input logic [2:0]        spi_cs_n,
    input logic              spi_sclk,
    input logic              spi_mosi,
    input logic [RX_W-1:0]   rx_word
);

    logic wr_pin;
    logic rise_wr;
    assign wr_pin  = bus_sel && bus_wr && bus_addr[3:2] == 2'd2 && fs_en;
    assign rise_wr = wr_pin && !spi_sclk && bus_wdata[SCLK_BIT];

    assert_idle_when_off_R2: assert property (@(posedge clk) disable iff (rst)
        !fs_en |-> (&spi_cs_n && spi_sclk));

    assert_route_gate_R4: assert property (@(posedge clk) disable iff (rst)
        ((~cs_route_en) & (~spi_cs_n)) == 3'b000);

    assert_pins_follow_R3: assert property (@(posedge clk) disable iff (rst)
        wr_pin |=> (spi_sclk == $past(bus_wdata[SCLK_BIT]) &&
                    spi_mosi == $past(bus_wdata[MOSI_BIT])));

    assert_shift_in_R6: assert property (@(posedge clk) disable iff (rst)
        rise_wr |=> rx_word[RX_W-1:1] == $past(rx_word[RX_W-2:0]));

    assert_hold_no_edge_R8: assert property (@(posedge clk) disable iff (rst)
        !rise_wr |=> $stable(rx_word));

endmodule

bind spi_bb_port spi_bb_port_chk #(.ADDR_W(ADDR_W), .RX_W(RX_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .fs_en       (fs_en),
    .cs_route_en (cs_route_en),
    .spi_cs_n    (spi_cs_n),
    .spi_sclk    (spi_sclk),
    .spi_mosi    (spi_mosi),
    .rx_word     (rx_word)
);

// File: tb/sim_spi_bb_port.sv
`timescale 1ns/1ps
module sim_spi_bb_port;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [2:0]  cs_route_en = 3'b111;
    logic        miso = 1'b0;
    logic [2:0]  spi_cs_n;
    logic        spi_sclk;
    logic        spi_mosi;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #4 clk = ~clk;

    spi_bb_port u0 (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cs_route_en(cs_route_en), .miso(miso),
        .spi_cs_n(spi_cs_n), .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
    );

    // {req[3:0], is_write, addr[3:0], data[31:0], miso, expect[31:0]}
    // write rows expect pins as {cs_n[2:0], sclk, mosi}; read rows expect read data
    localparam int NV = 24;
    localparam logic [73:0] VEC [NV] = '{
        {4'd1,  1'b0, 4'hC, 32'h0,        1'b0, 32'h0},        // R1 receive word empty
        {4'd1,  1'b0, 4'h8, 32'h0,        1'b0, 32'h00070100}, // R1 idle pin word
        {4'd2,  1'b1, 4'h8, 32'h0,        1'b0, 32'h1E},       // R2 ignored while off
        {4'd2,  1'b0, 4'h8, 32'h0,        1'b0, 32'h00070100}, // R2
        {4'd10, 1'b1, 4'h0, 32'h1,        1'b0, 32'h1E},       // R10 enable, still idle
        {4'd9,  1'b1, 4'h4, 32'hA5A51234, 1'b0, 32'h1E},       // R9
        {4'd9,  1'b0, 4'h4, 32'h0,        1'b0, 32'hA5A51234}, // R9
        {4'd3,  1'b1, 4'h8, 32'h00060001, 1'b1, 32'h19},       // R3 cs0 low, clk low
        {4'd5,  1'b1, 4'h8, 32'h00060101, 1'b1, 32'h1B},       // R5 rise, capture 1
        {4'd5,  1'b0, 4'hC, 32'h0,        1'b0, 32'h1},        // R5
        {4'd3,  1'b1, 4'h8, 32'h00060000, 1'b0, 32'h18},       // R3
        {4'd6,  1'b1, 4'h8, 32'h00060100, 1'b0, 32'h1A},       // R6 capture 0
        {4'd8,  1'b1, 4'h8, 32'h00060100, 1'b1, 32'h1A},       // R8 high to high
        {4'd8,  1'b1, 4'h8, 32'h00060000, 1'b1, 32'h18},       // R8 fall
        {4'd8,  1'b0, 4'hC, 32'h0,        1'b0, 32'h2},        // R8 still 0b10
        {4'd3,  1'b1, 4'h8, 32'h00050101, 1'b1, 32'h17},       // R3 cs1 low, capture 1
        {4'd7,  1'b0, 4'hC, 32'h0,        1'b0, 32'h5},        // R7
        {4'd7,  1'b0, 4'hC, 32'h0,        1'b0, 32'h5},        // R7 read does not clear
        {4'd9,  1'b1, 4'hC, 32'hFFFFFFFF, 1'b0, 32'h17},       // R9 write ignored
        {4'd9,  1'b0, 4'hC, 32'h0,        1'b0, 32'h5},        // R9
        {4'd3,  1'b0, 4'h8, 32'h0,        1'b0, 32'h00050101}, // R3 readback
        {4'd3,  1'b1, 4'h8, 32'hFFFFFFFF, 1'b0, 32'h1F},       // R3 masked write
        {4'd3,  1'b0, 4'h8, 32'h0,        1'b0, 32'h00070101}, // R3 only pin bits
        {4'd2,  1'b0, 4'h0, 32'h0,        1'b0, 32'h0}         // R2 select reads 0
    };

    task automatic check(input int req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] pin_view();
        return {27'd0, spi_cs_n, spi_sclk, spi_mosi};
    endfunction

    task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic set_miso(input logic b);
        @(negedge clk);
        miso = b;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_bits(input logic [31:0] v, input int nbits);
        for (int k = nbits - 1; k >= 0; k--) begin
            set_miso(v[k]);
            bus_write(4'h8, 32'h00060000 | {31'd0, v[k]});
            bus_write(4'h8, 32'h00060100 | {31'd0, v[k]});
        end
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(1, "reset pins", pin_view(), 32'h1E);

        for (int i = 0; i < NV; i++) begin
            logic [73:0] v;
            v = VEC[i];
            set_miso(v[32]);
            if (v[69]) begin
                bus_write(v[68:65], v[64:33]);
                check(int'(v[73:70]), $sformatf("row %0d pins", i), pin_view(), v[31:0]);
            end else begin
                bus_read(v[68:65], rd);
                check(int'(v[73:70]), $sformatf("row %0d read", i), rd, v[31:0]);
            end
        end

        // R6: full 32-bit fill, first bit lands in bit 31
        send_bits(32'hC35A0F96, 32);
        bus_read(4'hC, rd);
        check(6, "full word", rd, 32'hC35A0F96);
        check(6, "first byte on top", {24'd0, rd[31:24]}, 32'hC3);

        // R7: capture continues past 32 bits
        send_bits(32'h0000003C, 8);
        bus_read(4'hC, rd);
        check(7, "overflow shift", rd, 32'h5A0F963C);

        // R4: routing gate, combinational
        cs_route_en = 3'b001;
        bus_write(4'h8, 32'h00000100);
        check(4, "gated selects", pin_view(), 32'h1A);
        cs_route_en = 3'b111;
        #1 check(4, "routed selects", pin_view(), 32'h02);

        // R2 / R10: turn off, pins idle, pin word back to idle
        bus_write(4'h0, 32'h0);
        check(2, "off pins idle", pin_view(), 32'h1E);
        bus_write(4'h8, 32'h00000000);
        check(2, "write ignored when off", pin_view(), 32'h1E);
        bus_write(4'h0, 32'h1);
        check(10, "re-enabled idle", pin_view(), 32'h1E);
        bus_read(4'h8, rd);
        check(10, "pin word idle", rd, 32'h00070100);

        // R1 / R6: reset then short transfer lands low
        @(negedge clk); rst = 1'b1;
        repeat (2) @(negedge clk); rst = 1'b0;
        #1 check(1, "reset again pins", pin_view(), 32'h1E);
        bus_read(4'hC, rd);
        check(1, "reset clears receive", rd, 32'h0);
        bus_write(4'h0, 32'h1);
        send_bits(32'h0000BEEF, 16);
        bus_read(4'hC, rd);
        check(6, "partial low order", rd, 32'h0000BEEF);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule